// File: doc/BRIEF.md
# Predicated Vector Compaction Unit

This block takes one vector of VL bits, a byte-granular predicate and a 2-bit element-size code. It moves every active source element down into the lowest free destination element, keeping their relative order, and clears every destination element above the last one filled. It also reports how many elements were moved.

The predicate has one bit per byte of the vector. For a given element size, an element is active when the predicate bit of its lowest byte is set. The block accepts an operation on any cycle. The result and the count appear in registers on the following cycle, marked by a one-cycle `out_valid` pulse. Decode, register-file access and legality checks belong to the surrounding datapath.

Top module: `vec_compact`

## Requirements
- R1: Active source elements appear in the destination starting at element 0, in increasing source-index order, with no gaps.
- R2: Every destination element at an index at or above the packed count is all zeros.
- R3: The size code `esz` selects the element width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. The vector then holds VL divided by that width elements.
- R4: Element e of width W bits is active exactly when `pred[e*W/8]` is 1. The other predicate bits inside that element have no effect on the result or the count.
- R5: When no element is active for the selected size, `result` is all zeros and `count` is 0.
- R6: `count` equals the number of active elements for the selected size. Its range is 0 to VL/8.
- R7: `result` and `count` are loaded on the clock edge that accepts an input (`in_valid` high while `in_ready` is high). `out_valid` is high for exactly the next cycle. Without an accept, `result` and `count` hold their values and `out_valid` is low.
- R8: A synchronous active-low reset clears `out_valid`, `result` and `count` to zero.
- R9: `in_ready` is high out of reset, so operations on back-to-back cycles each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | Block can take an operation |
| src | input | VL | Source vector, element 0 in the low bits |
| pred | input | VL/8 | Predicate, one bit per byte |
| esz | input | 2 | Element size code (see R3) |
| out_valid | output | 1 | `result` and `count` are new this cycle |
| result | output | VL | Packed, zero-filled vector |
| count | output | clog2(VL/8+1) | Number of elements packed |

## Verification
The bench exercises each element size with sparse, dense, all-active and empty predicates. A design that indexes the predicate with the wrong stride or takes the wrong byte of an element would give a different count and a wrong packing. It also sets only the upper predicate bits of wide elements; a design that ORs the bits of an element would then wrongly report active elements. The bench runs back-to-back accepts, followed by idle cycles with a changed `src`, to expose a result register that drops an operation or follows the inputs while idle.

// File: rtl/vcmp_pkg.sv
// Shared definitions for the vector compaction unit.
// Assumes element widths are powers of two from 8 to 64 bits.
package vcmp_pkg;
    typedef enum logic [1:0] {
        ESZ_B8  = 2'b00,
        ESZ_B16 = 2'b01,
        ESZ_B32 = 2'b10,
        ESZ_B64 = 2'b11
    } esz_e;

    localparam int NUM_SIZES = 4;

    // Element width in bits for size index k.
    function automatic int elem_bits(input int k);
        return 8 << k;
    endfunction
endpackage

// File: rtl/vcmp_lane_mask.sv
// Derives one active-element mask for each element size from a byte-granular predicate.
// Assumes: element k-size e is active when the predicate bit of its lowest byte is set.
// Mask bits above the element count of a size are driven to zero.
module vcmp_lane_mask #(
    parameter int PL = 32
) (
    input  logic [PL-1:0] pred,
    output logic [PL-1:0] act [vcmp_pkg::NUM_SIZES]
);
    // Select the lowest-byte predicate bit of each element, for every size.
    for (genvar k = 0; k < vcmp_pkg::NUM_SIZES; k++) begin : g_size
        for (genvar e = 0; e < PL; e++) begin : g_elem
            if (e < (PL >> k)) begin : g_live
                assign act[k][e] = pred[e << k];
            end else begin : g_pad
                assign act[k][e] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vcmp_pack.sv
// Compacts active elements of one fixed width toward element 0 and zero-fills the rest.
// Assumes: VL is a multiple of ES; purely combinational, no state.
module vcmp_pack #(
    parameter int VL = 256,
    parameter int ES = 8,
    parameter int CW = 6
) (
    input  logic [VL-1:0]    src,
    input  logic [VL/ES-1:0] act,
    output logic [VL-1:0]    packed_o,
    output logic [CW-1:0]    cnt
);
    localparam int N = VL / ES;

    int slot;

    // Walk the source elements upward, writing each active one to the next free slot.
    always_comb begin
        packed_o = '0;
        slot     = 0;
        for (int e = 0; e < N; e++) begin
            if (act[e]) begin
                packed_o[slot*ES +: ES] = src[e*ES +: ES];
                slot = slot + 1;
            end
        end
        cnt = slot[CW-1:0];
    end
endmodule

// File: rtl/vec_compact.sv
// Predicated vector compaction unit, top level.
// Builds one packer per element size, selects the size named by esz, and registers the
// result and count on each accepted input. Assumes VL is a multiple of 64 and at least 128.
module vec_compact #(
    parameter int VL = 256,
    localparam int PL = VL / 8,
    localparam int CW = $clog2(PL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [VL-1:0] src,
    input  logic [PL-1:0] pred,
    input  logic [1:0]    esz,
    output logic          out_valid,
    output logic [VL-1:0] result,
    output logic [CW-1:0] count
);
    import vcmp_pkg::*;

    // Reject vector lengths the datapath is not built for.
    initial begin
        if ((VL % 64) != 0 || VL < 128) $error("vec_compact: VL must be a multiple of 64, at least 128");
    end

    logic [PL-1:0] act_k [NUM_SIZES];
    logic [VL-1:0] res_k [NUM_SIZES];
    logic [CW-1:0] cnt_k [NUM_SIZES];
    logic [PL-1:0] act_sel;
    logic [VL-1:0] res_sel;
    logic [CW-1:0] cnt_sel;
    logic          accept;

    assign in_ready = 1'b1;
    assign accept   = in_valid && in_ready;

    vcmp_lane_mask #(.PL(PL)) u_mask (
        .pred (pred),
        .act  (act_k)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_pack
        localparam int ES = elem_bits(k);
        vcmp_pack #(.VL(VL), .ES(ES), .CW(CW)) u_pack (
            .src      (src),
            .act      (act_k[k][VL/ES-1:0]),
            .packed_o (res_k[k]),
            .cnt      (cnt_k[k])
        );
    end

    // Pick the packer that matches the requested element size.
    always_comb begin
        act_sel = act_k[0];
        res_sel = res_k[0];
        cnt_sel = cnt_k[0];
        case (esz_e'(esz))
            ESZ_B8:  begin act_sel = act_k[0]; res_sel = res_k[0]; cnt_sel = cnt_k[0]; end
            ESZ_B16: begin act_sel = act_k[1]; res_sel = res_k[1]; cnt_sel = cnt_k[1]; end
            ESZ_B32: begin act_sel = act_k[2]; res_sel = res_k[2]; cnt_sel = cnt_k[2]; end
            ESZ_B64: begin act_sel = act_k[3]; res_sel = res_k[3]; cnt_sel = cnt_k[3]; end
            default: ;
        endcase
    end

    // Capture result and count on an accept; pulse out_valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            count     <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                result <= res_sel;
                count  <= cnt_sel;
            end
        end
    end

    // R7
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
    // R7
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!out_valid && $stable(result) && $stable(count)));
    // R6
    count_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (count == CW'($countones($past(act_sel)))));
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (32'(count) <= (PL >> $past(esz))));
    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && count == '0) |-> (result == '0));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && count == '0));
endmodule

// File: tb/sim_vec_compact.sv
module sim_vec_compact;
    localparam int VL = 256;
    localparam int PL = VL / 8;
    localparam int CW = $clog2(PL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VL-1:0] src = '0;
    logic [PL-1:0] pred = '0;
    logic [1:0]    esz = 2'b00;
    logic          out_valid;
    logic [VL-1:0] result;
    logic [CW-1:0] count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vec_compact #(.VL(VL)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src(src), .pred(pred), .esz(esz), .out_valid(out_valid),
        .result(result), .count(count)
    );

    // Reference from the requirements: lowest-byte predicate bit, ordered pack, zero fill.
    function automatic void model(input logic [VL-1:0] s, input logic [PL-1:0] p,
                                  input logic [1:0] z, output logic [VL-1:0] r, output int c);
        int w;
        w = 8 << z;
        r = '0;
        c = 0;
        for (int e = 0; e < VL / w; e++) begin
            if (p[e * w / 8]) begin
                for (int b = 0; b < w; b++) r[c * w + b] = s[e * w + b];
                c++;
            end
        end
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [VL-1:0] r, input int c);
        checks++;
        if (result !== r || count !== CW'(c) || out_valid !== 1'b1) begin
            errors++;
            $display("FAIL %s: got valid=%b count=%0d result=%h expected valid=1 count=%0d result=%h",
                     req, out_valid, count, result, c, r);
        end
    endtask

    // One accepted operation, checked one cycle later against the model.
    task automatic run_op(input string req, input logic [VL-1:0] s, input logic [PL-1:0] p,
                          input logic [1:0] z);
        logic [VL-1:0] r;
        int c;
        model(s, p, z, r, c);
        @(negedge clk);
        in_valid = 1'b1; src = s; pred = p; esz = z;
        @(negedge clk);
        in_valid = 1'b0;
        check_out(req, r, c);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_bit("R8 out_valid", out_valid, 1'b0);
        check_bit("R8 result zero", result == '0, 1'b1);
        check_bit("R8 count zero", count == '0, 1'b1);
        check_bit("R9 in_ready", in_ready, 1'b1);
    endtask

    task automatic t_all_active();
        for (int z = 0; z < 4; z++) run_op("R1 R3 all active", rand_vec(), '1, 2'(z));
    endtask

    task automatic t_none_active();
        for (int z = 0; z < 4; z++) run_op("R5 none active", rand_vec(), '0, 2'(z));
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 40; i++) run_op("R1 R2 R6 random", rand_vec(), PL'($urandom), 2'(i % 4));
        run_op("R1 R2 single top byte", rand_vec(), PL'(1) << (PL - 1), 2'b00);
        run_op("R2 alternating bytes", rand_vec(), {(PL/2){2'b10}}, 2'b00);
    endtask

    task automatic t_upper_bits_ignored();
        logic [PL-1:0] hi_only;
        logic [VL-1:0] s;
        hi_only = {(PL/8){8'hFE}};
        run_op("R4 wide upper bits only", rand_vec(), hi_only, 2'b11);
        run_op("R4 word upper bits only", rand_vec(), {(PL/4){4'hE}}, 2'b10);
        s = rand_vec();
        run_op("R4 low bit plus noise", s, {(PL/8){8'h5B}}, 2'b11);
    endtask

    task automatic t_back_to_back();
        logic [VL-1:0] s1, s2, r1, r2;
        logic [PL-1:0] p1, p2;
        int c1, c2;
        s1 = rand_vec(); s2 = rand_vec(); p1 = PL'($urandom); p2 = PL'($urandom);
        model(s1, p1, 2'b01, r1, c1);
        model(s2, p2, 2'b10, r2, c2);
        @(negedge clk);
        in_valid = 1'b1; src = s1; pred = p1; esz = 2'b01;
        @(negedge clk);
        check_out("R9 back-to-back first", r1, c1);
        src = s2; pred = p2; esz = 2'b10;
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R9 back-to-back second", r2, c2);
        // Idle with changed inputs: outputs hold, out_valid drops.
        src = rand_vec(); pred = '1; esz = 2'b00;
        @(negedge clk);
        check_bit("R7 out_valid one cycle", out_valid, 1'b0);
        check_bit("R7 result held", result == r2 && count == CW'(c2), 1'b1);
        repeat (3) @(negedge clk);
        check_bit("R7 still held", result == r2 && count == CW'(c2), 1'b1);
    endtask

    task automatic t_mid_reset();
        run_op("R1 before reset", rand_vec(), '1, 2'b00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_bit("R8 reset clears valid", out_valid, 1'b0);
        check_bit("R8 reset clears result", result == '0 && count == '0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_active();
        t_none_active();
        t_patterns();
        t_upper_bits_ignored();
        t_back_to_back();
        t_mid_reset();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule